// File: doc/BRIEF.md
# Bitmap Chunk Allocator

This block manages a pool of equal-sized memory chunks. It keeps one bit per chunk in an on-chip bitmap, where a set bit marks a chunk as taken and a clear bit marks it as free. A client sends commands over a valid/ready port. An allocate command asks for a number of adjacent chunks under one of four placement policies. The block scans the bitmap, claims the run it picks and returns the first chunk index of that run. A free command names a first chunk and a count, and the block clears those bits. A free run is simply a stretch of zero bits, so runs next to each other join up with no extra work.

The scan examines one chunk per clock and keeps track of the length of the free run it is currently in. The four policies are: lowest run that fits, first fit after a roving pointer, smallest run that fits, and largest run. Every command gets exactly one response, lasting one cycle, that carries an index and a status code.

The controller has five states:
- S_IDLE accepts a command. An allocate with a legal length goes to S_SCAN. An allocate of length 0 or longer than the pool goes straight to S_RESP. A free goes to S_CLEAR.
- S_SCAN moves to S_MARK when the search finds a run, and to S_RESP when it does not.
- S_MARK sets the chosen chunks and goes to S_RESP.
- S_CLEAR clears the named chunks and goes to S_RESP.
- S_RESP presents the response for one cycle and returns to S_IDLE.

Top module: `chunk_alloc`

## Requirements
- R1: After reset all 64 chunks are free, cmd_ready is 1, rsp_valid is 0 and the roving pointer is chunk 0.
- R2: A command is taken on a clock edge where cmd_valid and cmd_ready are both 1. cmd_ready stays 0 until the command's response has been given. Each command yields exactly one rsp_valid pulse of one cycle, and cmd_ready is 1 again in the cycle after it.
- R3: With cmd_op=0 (allocate) and cmd_policy=0, the result is the lowest-indexed free run of at least cmd_len chunks.
- R4: With cmd_policy=1, the search starts at the roving pointer and walks upward. It wraps from chunk 63 to chunk 0 and stops after one full pass. It returns the first fitting run it reaches. A run never spans the step from chunk 63 to chunk 0.
- R5: With cmd_policy=2, the result is the smallest free run whose length is at least cmd_len. Between runs of equal length, the lower index wins.
- R6: With cmd_policy=3, the result is the largest free run whose length is at least cmd_len. Between runs of equal length, the lower index wins.
- R7: An allocate fails in three cases: cmd_len is 0, cmd_len is above 64, or no run fits. A failed allocate returns rsp_status=1 and rsp_index=0 and leaves the bitmap unchanged.
- R8: A successful allocate returns rsp_status=0 and the start index. It marks chunks index to index+len-1 as taken, and only free chunks are ever marked.
- R9: A free command (cmd_op=1) clears chunks cmd_start up to cmd_start+cmd_len-1, and any part above chunk 63 is ignored. It returns rsp_index=0. rsp_status is 0 if every chunk in the range was taken. If any chunk in the range was already free, rsp_status is 2, and the range is still cleared.
- R10: Only a successful allocate moves the roving pointer. It then points to the chunk just after the new run, wrapping to 0 after chunk 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 1 | 0 = allocate, 1 = free |
| cmd_policy | input | 2 | 0 lowest fit, 1 roving fit, 2 smallest fit, 3 largest fit |
| cmd_len | input | 7 | Number of chunks |
| cmd_start | input | 6 | First chunk of a free command |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_index | output | 6 | First chunk of the allocated run, 0 otherwise |
| rsp_status | output | 2 | 0 ok, 1 no fit, 2 range held free chunks |

## Verification
The allocation results are checked against a pool that is built up step by step. It contains holes of different sizes, so a single layout gives a different index under each policy. The roving policy is tried from a pointer in the middle of the pool and from one near the top. This shows the difference between restarting at chunk 0 and resuming where the last allocation ended, and it shows that a run split across the wrap point is refused. Equal-length runs check the lower-index tie rule for both the smallest and the largest fit. An exact-size hole is placed ahead of larger ones, and a non-exact smallest hole is placed ahead of larger ones. Frees that overlap existing holes check the error code and the merging of neighbouring holes, and a free that runs past chunk 63 checks that the excess is ignored.

// File: rtl/chunk_alloc_pkg.sv
package chunk_alloc_pkg;

    typedef enum logic {
        OP_ALLOC = 1'b0,
        OP_FREE  = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        FIT_FIRST = 2'd0,
        FIT_NEXT  = 2'd1,
        FIT_BEST  = 2'd2,
        FIT_WORST = 2'd3
    } fit_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_NOFIT   = 2'd1,
        ST_DBLFREE = 2'd2
    } rsp_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_MARK,
        S_CLEAR,
        S_RESP
    } state_e;

endpackage

// File: rtl/chunk_bitmap.sv
module chunk_bitmap #(
    parameter int NCHUNK = 64,
    parameter int IDX_W  = 6,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  rng_lo,
    input  logic [LEN_W-1:0]  rng_len,
    output logic [NCHUNK-1:0] map,
    output logic              rng_has_free
);
    localparam int SUM_W = LEN_W + 1;

    logic [NCHUNK-1:0] in_rng;
    logic [SUM_W-1:0]  rng_hi;

    assign rng_hi = SUM_W'(rng_lo) + SUM_W'(rng_len);

    // One comparator pair per chunk builds the range mask.
    for (genvar i = 0; i < NCHUNK; i++) begin : g_mask
        assign in_rng[i] = (SUM_W'(i) >= SUM_W'(rng_lo)) && (SUM_W'(i) < rng_hi);
    end

    assign rng_has_free = |(in_rng & ~map);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map <= '0;
        end else if (set_en) begin
            map <= map | in_rng;
        end else if (clr_en) begin
            map <= map & ~in_rng;
        end
    end

    AST_MARK_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> ((map & in_rng) == '0)); // R8

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((map & $past(in_rng)) == '0)); // R9

endmodule

// File: rtl/chunk_scan.sv
module chunk_scan
    import chunk_alloc_pkg::*;
#(
    parameter int NCHUNK = 64,
    parameter int IDX_W  = 6,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              active,
    input  logic [IDX_W-1:0]  origin,
    input  logic [1:0]        policy,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [NCHUNK-1:0] map,
    output logic              done,
    output logic              found,
    output logic [IDX_W-1:0]  found_idx
);
    localparam int LAST  = NCHUNK - 1;
    localparam int SUM_W = LEN_W + 1;

    fit_e             pol;
    logic [IDX_W-1:0] pos, steps, nxt_pos;
    logic [IDX_W-1:0] run_start, new_start, cand_start;
    logic [LEN_W-1:0] run_len, prev_len, new_len, cand_len;
    logic             cand_valid;
    logic             at_end, cur_free, nxt_free, run_ends, big;
    logic             fit_hit, q_best, q_worst, qualify, exact, last_step;

    assign pol = fit_e'(policy);

    always_comb begin
        at_end    = (pos == IDX_W'(LAST));
        nxt_pos   = at_end ? '0 : pos + 1'b1;
        cur_free  = !map[pos];
        nxt_free  = !map[nxt_pos];
        // a run never carries across the wrap from the top chunk to chunk 0
        prev_len  = (pos == '0) ? '0 : run_len;
        new_len   = cur_free ? prev_len + 1'b1 : '0;
        new_start = (prev_len == '0) ? pos : run_start;
        run_ends  = cur_free && (at_end || !nxt_free);
        big       = (new_len >= req_len);
        fit_hit   = ((pol == FIT_FIRST) || (pol == FIT_NEXT)) && cur_free && (new_len == req_len);
        q_best    = (pol == FIT_BEST) && run_ends && big && (!cand_valid || (new_len < cand_len));
        q_worst   = (pol == FIT_WORST) && run_ends && big && (!cand_valid || (new_len > cand_len));
        qualify   = q_best || q_worst;
        exact     = q_best && (new_len == req_len);
        last_step = (steps == IDX_W'(LAST));
        done      = active && (fit_hit || exact || last_step);
        found     = fit_hit || qualify || cand_valid;
        found_idx = (fit_hit || qualify) ? new_start : cand_start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos        <= '0;
            steps      <= '0;
            run_len    <= '0;
            run_start  <= '0;
            cand_valid <= 1'b0;
            cand_len   <= '0;
            cand_start <= '0;
        end else if (init) begin
            pos        <= origin;
            steps      <= '0;
            run_len    <= '0;
            run_start  <= origin;
            cand_valid <= 1'b0;
            cand_len   <= '0;
            cand_start <= '0;
        end else if (active && !done) begin
            pos       <= nxt_pos;
            steps     <= steps + 1'b1;
            run_len   <= new_len;
            run_start <= new_start;
            if (qualify) begin
                cand_valid <= 1'b1;
                cand_len   <= new_len;
                cand_start <= new_start;
            end
        end
    end

    AST_NO_STRADDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> ((SUM_W'(found_idx) + SUM_W'(req_len)) <= SUM_W'(NCHUNK))); // R4

endmodule

// File: rtl/chunk_alloc.sv
module chunk_alloc
    import chunk_alloc_pkg::*;
#(
    parameter  int NCHUNK = 64,
    localparam int IDX_W  = $clog2(NCHUNK),
    localparam int LEN_W  = $clog2(NCHUNK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_op,
    input  logic [1:0]       cmd_policy,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [IDX_W-1:0] cmd_start,
    output logic             rsp_valid,
    output logic [IDX_W-1:0] rsp_index,
    output logic [1:0]       rsp_status
);
    localparam int SUM_W = LEN_W + 1;

    state_e            state, nxt_state;
    op_e               op_q;
    logic [1:0]        pol_q;
    logic [LEN_W-1:0]  len_q;
    logic [IDX_W-1:0]  lo_q, rover, rover_nxt, origin;
    logic [IDX_W-1:0]  rsp_idx_q;
    rsp_e              rsp_st_q;
    logic              accept, bad_len;
    logic              scan_init, scan_active, set_en, clr_en;
    logic              scan_done, scan_found;
    logic [IDX_W-1:0]  scan_idx;
    logic [NCHUNK-1:0] map;
    logic              rng_has_free;
    logic [SUM_W-1:0]  end_sum;

    assign accept  = cmd_valid && (state == S_IDLE);
    assign bad_len = (cmd_len == '0) || (cmd_len > LEN_W'(NCHUNK));
    assign origin  = (fit_e'(cmd_policy) == FIT_NEXT) ? rover : '0;
    assign end_sum = SUM_W'(lo_q) + SUM_W'(len_q);
    assign rover_nxt = (end_sum >= SUM_W'(NCHUNK)) ? IDX_W'(end_sum - SUM_W'(NCHUNK))
                                                   : IDX_W'(end_sum);

    chunk_bitmap #(.NCHUNK(NCHUNK), .IDX_W(IDX_W), .LEN_W(LEN_W)) bitmap_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_en       (set_en),
        .clr_en       (clr_en),
        .rng_lo       (lo_q),
        .rng_len      (len_q),
        .map          (map),
        .rng_has_free (rng_has_free)
    );

    chunk_scan #(.NCHUNK(NCHUNK), .IDX_W(IDX_W), .LEN_W(LEN_W)) scan_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (scan_init),
        .active    (scan_active),
        .origin    (origin),
        .policy    (pol_q),
        .req_len   (len_q),
        .map       (map),
        .done      (scan_done),
        .found     (scan_found),
        .found_idx (scan_idx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt_state;
    end

    // Next state and control outputs
    always_comb begin
        nxt_state   = state;
        scan_init   = 1'b0;
        scan_active = 1'b0;
        set_en      = 1'b0;
        clr_en      = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (cmd_valid) begin
                    if (op_e'(cmd_op) == OP_FREE) begin
                        nxt_state = S_CLEAR;
                    end else if (bad_len) begin
                        nxt_state = S_RESP;
                    end else begin
                        nxt_state = S_SCAN;
                        scan_init = 1'b1;
                    end
                end
            end
            S_SCAN: begin
                scan_active = 1'b1;
                if (scan_done) nxt_state = scan_found ? S_MARK : S_RESP;
            end
            S_MARK: begin
                set_en    = 1'b1;
                nxt_state = S_RESP;
            end
            S_CLEAR: begin
                clr_en    = 1'b1;
                nxt_state = S_RESP;
            end
            S_RESP:  nxt_state = S_IDLE;
            default: nxt_state = S_IDLE;
        endcase
    end

    // Command and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_ALLOC;
            pol_q     <= '0;
            len_q     <= '0;
            lo_q      <= '0;
            rover     <= '0;
            rsp_idx_q <= '0;
            rsp_st_q  <= ST_OK;
        end else begin
            if (accept) begin
                op_q      <= op_e'(cmd_op);
                pol_q     <= cmd_policy;
                len_q     <= cmd_len;
                lo_q      <= cmd_start;
                rsp_idx_q <= '0;
                rsp_st_q  <= ((op_e'(cmd_op) == OP_ALLOC) && bad_len) ? ST_NOFIT : ST_OK;
            end
            if ((state == S_SCAN) && scan_done) begin
                if (scan_found) begin
                    lo_q      <= scan_idx;
                    rsp_idx_q <= scan_idx;
                end else begin
                    rsp_st_q  <= ST_NOFIT;
                end
            end
            if (state == S_MARK)  rover    <= rover_nxt;
            if (state == S_CLEAR) rsp_st_q <= rng_has_free ? ST_DBLFREE : ST_OK;
        end
    end

    assign cmd_ready  = (state == S_IDLE);
    assign rsp_valid  = (state == S_RESP);
    assign rsp_index  = rsp_idx_q;
    assign rsp_status = rsp_st_q;

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && cmd_ready)); // R2

    AST_BAD_LEN_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (op_q == OP_ALLOC) && ((len_q == '0) || (len_q > LEN_W'(NCHUNK))))
        |-> (rsp_status == ST_NOFIT)); // R7

    AST_ROVER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rover) |-> ($past(state) == S_MARK)); // R10

    AST_FAIL_KEEPS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_SCAN) && scan_done && !scan_found) |=> $stable(map)); // R7

endmodule

// File: tb/chunk_alloc_tb.sv
module chunk_alloc_tb_top;

    typedef struct packed {
        logic       op;
        logic [1:0] pol;
        logic [6:0] len;
        logic [5:0] start;
        logic [5:0] idx;
        logic [1:0] st;
    } vec_t;

    localparam int NV = 39;
    // op 0 alloc / 1 free; pol 0 lowest, 1 roving, 2 smallest, 3 largest; st 0 ok, 1 nofit, 2 free error
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 7'd10,  6'd0,  6'd0,  2'd0},  // R3
        '{1'b0, 2'd0, 7'd5,   6'd0,  6'd10, 2'd0},
        '{1'b0, 2'd0, 7'd8,   6'd0,  6'd15, 2'd0},
        '{1'b0, 2'd0, 7'd4,   6'd0,  6'd23, 2'd0},
        '{1'b1, 2'd0, 7'd5,   6'd10, 6'd0,  2'd0},  // R9
        '{1'b1, 2'd0, 7'd4,   6'd23, 6'd0,  2'd0},
        '{1'b0, 2'd1, 7'd3,   6'd0,  6'd27, 2'd0},  // R4 resumes at 27, lowest fit would give 10
        '{1'b0, 2'd2, 7'd4,   6'd0,  6'd23, 2'd0},  // R5 exact hole
        '{1'b0, 2'd3, 7'd2,   6'd0,  6'd30, 2'd0},  // R6
        '{1'b0, 2'd2, 7'd5,   6'd0,  6'd10, 2'd0},
        '{1'b0, 2'd0, 7'd33,  6'd0,  6'd0,  2'd1},  // R7 no run fits
        '{1'b0, 2'd0, 7'd0,   6'd0,  6'd0,  2'd1},  // R7 zero length
        '{1'b0, 2'd0, 7'd32,  6'd0,  6'd32, 2'd0},  // pool now full
        '{1'b1, 2'd0, 7'd4,   6'd0,  6'd0,  2'd0},
        '{1'b1, 2'd0, 7'd4,   6'd2,  6'd0,  2'd2},  // R9 overlaps a hole
        '{1'b0, 2'd0, 7'd6,   6'd0,  6'd0,  2'd0},  // R9 merged hole 0..5
        '{1'b0, 2'd3, 7'd1,   6'd0,  6'd0,  2'd1},
        '{1'b1, 2'd0, 7'd4,   6'd60, 6'd0,  2'd0},
        '{1'b1, 2'd0, 7'd2,   6'd0,  6'd0,  2'd0},
        '{1'b1, 2'd0, 7'd2,   6'd20, 6'd0,  2'd0},
        '{1'b0, 2'd1, 7'd5,   6'd0,  6'd0,  2'd1},  // R4 no straddle of 60..63 + 0..1
        '{1'b0, 2'd1, 7'd4,   6'd0,  6'd60, 2'd0},  // R10 pointer still 6 after failure
        '{1'b0, 2'd1, 7'd2,   6'd0,  6'd0,  2'd0},  // R10 pointer wrapped to 0
        '{1'b1, 2'd0, 7'd10,  6'd60, 6'd0,  2'd0},  // R9 excess above 63 ignored
        '{1'b1, 2'd0, 7'd4,   6'd40, 6'd0,  2'd0},
        '{1'b0, 2'd3, 7'd1,   6'd0,  6'd40, 2'd0},  // R6 tie 40 vs 60
        '{1'b1, 2'd0, 7'd3,   6'd0,  6'd0,  2'd0},
        '{1'b0, 2'd2, 7'd3,   6'd0,  6'd0,  2'd0},  // R5 tie 0 vs 41
        '{1'b0, 2'd2, 7'd3,   6'd0,  6'd41, 2'd0},
        '{1'b0, 2'd1, 7'd2,   6'd0,  6'd60, 2'd0},  // R4 from 44
        '{1'b0, 2'd1, 7'd2,   6'd0,  6'd62, 2'd0},
        '{1'b0, 2'd0, 7'd2,   6'd0,  6'd20, 2'd0},
        '{1'b0, 2'd0, 7'd1,   6'd0,  6'd0,  2'd1},
        '{1'b1, 2'd0, 7'd3,   6'd10, 6'd0,  2'd0},
        '{1'b1, 2'd0, 7'd5,   6'd30, 6'd0,  2'd0},
        '{1'b1, 2'd0, 7'd4,   6'd50, 6'd0,  2'd0},
        '{1'b0, 2'd2, 7'd2,   6'd0,  6'd10, 2'd0},  // R5 non-exact smallest
        '{1'b0, 2'd3, 7'd2,   6'd0,  6'd30, 2'd0},  // R6
        '{1'b0, 2'd0, 7'd100, 6'd0,  6'd0,  2'd1}   // R7 over-long
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic       cmd_op = 1'b0;
    logic [1:0] cmd_policy = '0;
    logic [6:0] cmd_len = '0;
    logic [5:0] cmd_start = '0;
    logic       rsp_valid;
    logic [5:0] rsp_index;
    logic [1:0] rsp_status;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    chunk_alloc dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_op     (cmd_op),
        .cmd_policy (cmd_policy),
        .cmd_len    (cmd_len),
        .cmd_start  (cmd_start),
        .rsp_valid  (rsp_valid),
        .rsp_index  (rsp_index),
        .rsp_status (rsp_status)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL R2 watchdog expired: actual %0d cycles expected under 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.op) return "R9";
        if (v.st != 2'd0) return "R7";
        case (v.pol)
            2'd0:    return "R3 R8";
            2'd1:    return "R4 R8";
            2'd2:    return "R5 R8";
            default: return "R6 R8";
        endcase
    endfunction

    task automatic run_cmd(input vec_t v, input string tag);
        int wait_n = 0;
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_op     = v.op;
        cmd_policy = v.pol;
        cmd_len    = v.len;
        cmd_start  = v.start;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(!cmd_ready, "R2", "cmd_ready while busy", int'(cmd_ready), 0);
        while (!rsp_valid && wait_n < 500) begin
            @(negedge clk);
            wait_n++;
        end
        check(rsp_valid, "R2", "response arrived", int'(rsp_valid), 1);
        check(rsp_status == v.st, tag, "rsp_status", int'(rsp_status), int'(v.st));
        check(rsp_index == v.idx, tag, "rsp_index", int'(rsp_index), int'(v.idx));
        @(negedge clk);
        check(!rsp_valid && cmd_ready, "R2", "pulse ends and ready returns",
              int'({rsp_valid, cmd_ready}), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cmd_ready == 1'b1, "R1", "cmd_ready in reset", int'(cmd_ready), 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1 && rsp_valid == 1'b0, "R1", "idle after reset",
              int'({cmd_ready, rsp_valid}), 2);

        for (int i = 0; i < NV; i++) begin
            run_cmd(VECS[i], tag_of(VECS[i]));
        end

        // R1: reset mid-run empties the pool and puts the roving pointer at 0
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_cmd('{1'b0, 2'd1, 7'd64, 6'd0, 6'd0, 2'd0}, "R1");
        // R9: whole pool held, free of all of it is clean
        run_cmd('{1'b1, 2'd0, 7'd64, 6'd0, 6'd0, 2'd0}, "R9");
        // R9: second free of the same range reports the error
        run_cmd('{1'b1, 2'd0, 7'd8, 6'd8, 6'd0, 2'd2}, "R9");
        // R3: pool empty again after the frees
        run_cmd('{1'b0, 2'd0, 7'd64, 6'd0, 6'd0, 2'd0}, "R3");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule